// File: doc/BRIEF.md
# Stack-Based Expression Evaluator

This block evaluates arithmetic expressions held on a small internal hardware stack. Arithmetic commands carry no operand fields: they take their two sources from the top of the stack and leave one result in their place. Only two commands name an explicit value. A push brings a word in through the data input. A pop hands the top word back on a registered result output.

A producer issues one command per cycle over a valid/ready handshake. The expression `C = A + B` becomes the four commands push A, push B, add, pop. After them the result port carries A+B and the stack is empty again. Commands stay compact because they carry no operand fields, but each expression needs more of them.

Illegal commands leave the stack untouched and raise sticky status flags. These are a push onto a full stack, a pop from an empty stack, and an arithmetic command with fewer than two entries present. The flags stay set until reset.

Top module: `stack_eval_unit`

## Requirements
- R1: While `rst` is high, `cmd_ready` is 0. After the first clock edge with `rst` low, `cmd_ready` is 1, `depth` is 0, both error flags are 0 and `res_valid` is 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. An accepted push (`cmd_op` = 1) on a non-full stack places `cmd_data` on top and raises `depth` by one.
- R3: An accepted pop (`cmd_op` = 2) on a non-empty stack removes the top word and lowers `depth` by one. In the cycle after acceptance, and only then, `res_valid` is 1 and `res_data` holds the removed word.
- R4: An accepted add (`cmd_op` = 3) with at least two entries replaces the two top words with their sum modulo 2^32, lowering `depth` by one.
- R5: An accepted subtract (`cmd_op` = 4) replaces the two top words with the second-from-top minus the top, modulo 2^32.
- R6: The logic commands bitwise AND (`cmd_op` = 5), OR (`cmd_op` = 6) and XOR (`cmd_op` = 7) replace the two top words with their bitwise combination.
- R7: A push when `depth` is 8 sets `err_overflow` and leaves every stored word and `depth` unchanged.
- R8: A pop with `depth` 0, or an arithmetic or logic command with `depth` below 2, sets `err_underflow`. It leaves the stack and `depth` unchanged and produces no `res_valid` pulse.
- R9: Code 0 is a no-operation. A cycle with `cmd_valid` low also changes nothing, whatever `cmd_op` and `cmd_data` hold.
- R10: Words come back in last-in, first-out order.
- R11: Once set, either error flag stays set until reset, whatever commands follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_op | input | 3 | Command code (0 nop, 1 push, 2 pop, 3 add, 4 sub, 5 and, 6 or, 7 xor) |
| cmd_data | input | 32 | Push operand |
| res_valid | output | 1 | One-cycle pulse: `res_data` holds a popped word |
| res_data | output | 32 | Popped word, registered |
| depth | output | 4 | Number of occupied entries, 0 to 8 |
| err_overflow | output | 1 | Sticky: push attempted on a full stack |
| err_underflow | output | 1 | Sticky: too few entries for a pop or an arithmetic command |

## Verification
The bench targets the depth boundaries: a push at depth 8, and a pop or binary command at depth 0 and at depth 1. A design that mishandles these would wrap its counter and corrupt the bottom entry, or pulse a stale result. Subtraction is checked with operands whose order matters. Swapping the sources shows up as a negated result. Carry wrap-around at the 32-bit boundary is also covered. A long pseudo-random command stream is compared against a software stack model, which catches error flags that clear themselves or results presented a cycle early or late.

// File: rtl/stack_eval_pkg.sv
package stack_eval_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } stk_op_e;

  function automatic logic op_is_binary(stk_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/stack_eval_alu.sv
module stack_eval_alu
  import stack_eval_pkg::*;
#(
  parameter int W = 32
) (
  input  stk_op_e        op,
  input  logic [W-1:0]   lhs,   // second from top
  input  logic [W-1:0]   rhs,   // top
  output logic [W-1:0]   result
);

  always_comb begin
    unique case (op)
      OP_ADD:  result = lhs + rhs;
      OP_SUB:  result = lhs - rhs;   // operand order follows push order
      OP_AND:  result = lhs & rhs;
      OP_OR:   result = lhs | rhs;
      OP_XOR:  result = lhs ^ rhs;
      default: result = lhs;
    endcase
  end

endmodule

// File: rtl/stack_eval_mem.sv
// Entry storage: one synchronous write port, two asynchronous read ports,
// suited to LUT-based distributed RAM.
module stack_eval_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_top,
  input  logic [AW-1:0] raddr_nxt,
  output logic [W-1:0]  rdata_top,
  output logic [W-1:0]  rdata_nxt
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_top = cells[raddr_top];
  assign rdata_nxt = cells[raddr_nxt];

endmodule

// File: rtl/stack_eval_ctrl.sv
module stack_eval_ctrl
  import stack_eval_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  stk_op_e       op,
  output logic [CW-1:0] depth_q,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          bin_ok,
  output logic          ovf_q,
  output logic          unf_q
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] TWO_CNT  = CW'(2);

  logic is_push, is_pop, is_bin;
  logic push_bad, pop_bad, bin_bad;

  assign is_push  = fire && (op == OP_PUSH);
  assign is_pop   = fire && (op == OP_POP);
  assign is_bin   = fire && op_is_binary(op);

  assign push_ok  = is_push && (depth_q != FULL_CNT);
  assign push_bad = is_push && (depth_q == FULL_CNT);
  assign pop_ok   = is_pop  && (depth_q != '0);
  assign pop_bad  = is_pop  && (depth_q == '0);
  assign bin_ok   = is_bin  && (depth_q >= TWO_CNT);
  assign bin_bad  = is_bin  && (depth_q <  TWO_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (push_ok)
        depth_q <= depth_q + CW'(1);
      else if (pop_ok || bin_ok)
        depth_q <= depth_q - CW'(1);
      if (push_bad)
        ovf_q <= 1'b1;
      if (pop_bad || bin_bad)
        unf_q <= 1'b1;
    end
  end

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
    depth_q <= FULL_CNT);

  p_full_push_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_PUSH && depth_q == FULL_CNT) |=> (ovf_q && $stable(depth_q)));

  p_short_operand_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && op_is_binary(op) && depth_q < TWO_CNT) |=> (unf_q && $stable(depth_q)));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_POP && depth_q == '0) |=> (unf_q && $stable(depth_q)));

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);

  p_unf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    unf_q |=> unf_q);

endmodule

// File: rtl/stack_eval_unit.sv
module stack_eval_unit
  import stack_eval_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic          res_valid,
  output logic [W-1:0]  res_data,
  output logic [CW-1:0] depth,
  output logic          err_overflow,
  output logic          err_underflow
);

  stk_op_e       op;
  logic          fire;
  logic          rdy_q;
  logic [CW-1:0] depth_q;
  logic          push_ok, pop_ok, bin_ok;
  logic          ovf_q, unf_q;
  logic [W-1:0]  top_w, nxt_w, alu_w;
  logic [AW-1:0] addr_top, addr_nxt, addr_wr;
  logic          mem_we;
  logic [W-1:0]  mem_wdata;
  logic          rv_q;
  logic [W-1:0]  rd_q;

  assign op   = stk_op_e'(cmd_op);
  assign fire = cmd_valid && rdy_q;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  stack_eval_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .op      (op),
    .depth_q (depth_q),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .bin_ok  (bin_ok),
    .ovf_q   (ovf_q),
    .unf_q   (unf_q)
  );

  assign addr_top  = AW'(depth_q - CW'(1));
  assign addr_nxt  = AW'(depth_q - CW'(2));
  assign addr_wr   = push_ok ? AW'(depth_q) : addr_nxt;
  assign mem_we    = push_ok || bin_ok;
  assign mem_wdata = push_ok ? cmd_data : alu_w;

  stack_eval_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk       (clk),
    .we        (mem_we),
    .waddr     (addr_wr),
    .wdata     (mem_wdata),
    .raddr_top (addr_top),
    .raddr_nxt (addr_nxt),
    .rdata_top (top_w),
    .rdata_nxt (nxt_w)
  );

  stack_eval_alu #(.W(W)) u_alu (
    .op     (op),
    .lhs    (nxt_w),
    .rhs    (top_w),
    .result (alu_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= pop_ok;
      if (pop_ok) rd_q <= top_w;
    end
  end

  assign cmd_ready     = rdy_q;
  assign res_valid     = rv_q;
  assign res_data      = rd_q;
  assign depth         = depth_q;
  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;

  p_result_source_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(cmd_valid && cmd_ready && cmd_op == 3'd2 && depth != '0));

  p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 3'd2 && depth != '0) |=>
      (res_valid && depth == $past(depth) - CW'(1)));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 3'd1 && depth != CW'(DEPTH)) |=>
      (depth == $past(depth) + CW'(1)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || cmd_op == 3'd0) |=> ($stable(depth) && !res_valid));

endmodule

// File: tb/stack_eval_unit_tb.sv
module stack_eval_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        res_valid;
  logic [31:0] res_data;
  logic [3:0]  depth;
  logic        err_overflow;
  logic        err_underflow;

  always #10 clk = ~clk;   // 50 MHz

  stack_eval_unit u_dut (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_data      (cmd_data),
    .res_valid     (res_valid),
    .res_data      (res_data),
    .depth         (depth),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] model[$];
  logic        m_ovf;
  logic        m_unf;
  logic [31:0] lcg;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] calc(input logic [2:0] op,
                                       input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd3:    return a + b;
      3'd4:    return a - b;
      3'd5:    return a & b;
      3'd6:    return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R9";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Issue one accepted command, update the model, compare all outputs.
  task automatic issue(input logic [2:0] op, input logic [31:0] data);
    logic        exp_rv;
    logic [31:0] exp_rd, a, b;
    string       rq;
    exp_rv = 1'b0;
    exp_rd = '0;
    rq = req_of(op);
    case (op)
      3'd0: ;
      3'd1: if (model.size() == 8) begin m_ovf = 1'b1; rq = "R7"; end
            else model.push_back(data);
      3'd2: if (model.size() == 0) begin m_unf = 1'b1; rq = "R8"; end
            else begin exp_rd = model.pop_back(); exp_rv = 1'b1; end
      default:
            if (model.size() < 2) begin m_unf = 1'b1; rq = "R8"; end
            else begin
              b = model.pop_back();
              a = model.pop_back();
              model.push_back(calc(op, a, b));
            end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rq, "res_valid", 32'(res_valid), 32'(exp_rv));
    if (exp_rv) check(rq, "res_data", res_data, exp_rd);
    check(rq, "depth", 32'(depth), 32'(model.size()));
    check((rq == "R7") ? "R7" : "R11", "err_overflow", 32'(err_overflow), 32'(m_ovf));
    check((rq == "R8") ? "R8" : "R11", "err_underflow", 32'(err_underflow), 32'(m_unf));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R1", "cmd_ready in reset", 32'(cmd_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    model.delete();
    m_ovf = 1'b0;
    m_unf = 1'b0;
    check("R1", "cmd_ready", 32'(cmd_ready), 32'd1);
    check("R1", "depth", 32'(depth), 32'd0);
    check("R1", "err_overflow", 32'(err_overflow), 32'd0);
    check("R1", "err_underflow", 32'(err_underflow), 32'd0);
    check("R1", "res_valid", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog act=timeout exp=finished");
    finish_up();
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    rst = 1'b1;
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
    cmd_data = '0;
    lcg = 32'h1234_5678;
    pa = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 32'hA5A5_A5A5};
    pb = '{32'h0, 32'h1, 32'h1, 32'h1, 32'h8000_0000, 32'h5A5A_F00F};
    repeat (3) @(negedge clk);
    do_reset();

    // R4 R5 R6: every binary command over operand pairs, result popped back
    for (int op = 3; op <= 7; op++) begin
      for (int i = 0; i < 6; i++) begin
        issue(3'd1, pa[i]);
        issue(3'd1, pb[i]);
        issue(3'(op), 32'h0);
        issue(3'd2, 32'h0);
      end
    end

    // R9: nop and valid-low cycles change nothing
    issue(3'd1, 32'hCAFE_0001);
    issue(3'd0, 32'hDEAD_BEEF);
    for (int op = 0; op < 8; op++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'(op);
      cmd_data  = 32'hBAD0_0000 + 32'(op);
      @(negedge clk);
      check("R9", "depth idle", 32'(depth), 32'd1);
      check("R9", "res_valid idle", 32'(res_valid), 32'd0);
    end
    issue(3'd2, 32'h0);

    // R8: underflow at depth 0 and depth 1 for each consuming command
    do_reset();
    issue(3'd2, 32'h0);
    for (int op = 3; op <= 7; op++) issue(3'(op), 32'h0);
    issue(3'd1, 32'h0000_0077);
    for (int op = 3; op <= 7; op++) issue(3'(op), 32'h0);
    issue(3'd2, 32'h0);   // the lone entry survives the rejected commands

    // R7 R10: fill, overflow, drain in reverse order, then empty pop
    do_reset();
    for (int k = 0; k < 8; k++) issue(3'd1, 32'h1000_0000 + 32'(k));
    issue(3'd1, 32'hFFFF_0000);
    for (int k = 7; k >= 0; k--) begin
      issue(3'd2, 32'h0);
      check("R10", "lifo word", res_data, 32'h1000_0000 + 32'(k));
    end
    issue(3'd2, 32'h0);

    // R11: flags survive legal traffic; pseudo-random stream against the model
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      op = lcg[30:28];
      if (lcg[25:24] == 2'b00) op = 3'd1;
      issue(op, lcg ^ {lcg[15:0], lcg[31:16]});
    end

    finish_up();
  end

endmodule